// File: doc/BRIEF.md
# Multi-mode operand address and fetch unit

This unit sits between instruction decode and the execute stage. For each accepted request it takes a decoded addressing-mode code, the address or displacement field of the instruction, a register number, that register's contents and the current program counter. From these it forms the effective address. It then walks zero to three memory reads over a single-port read interface to obtain the operand. Each level of indirection costs one more read. The unit counts those reads.

When it finishes, the unit gives a one-cycle completion strobe together with the operand, the effective address and the read count. The modes that step a pointer also raise a writeback strobe carrying the updated register value and the register number. The register file that consumes this writeback lives outside the unit. The pointer step is a parameter. Pre-decrement only produces the address for a store: the write itself is done by other logic.

Top module: `opfetch_unit`

## Requirements
- R1: While and after reset, `busy`, `done`, `mem_req` and `wb_en` are low, and `operand`, `eff_addr` and `rd_count` are zero.
- R2: Mode code 0 (immediate) returns `operand` = field. Mode code 1 (register) returns `operand` = reg_val. Both give `eff_addr` = 0 and `rd_count` = 0 with no memory request. Codes 11 to 15 behave exactly like immediate.
- R3: Mode 2 (direct) reads once at the field value. Mode 3 (register-indirect) reads once at reg_val. In both, `operand` is the returned data, `eff_addr` is the read address and `rd_count` = 1.
- R4: Mode 4 (memory-indirect) reads a pointer at the field value and then the operand at that pointer, giving `rd_count` = 2. Mode 5 (double-indirect) follows one more pointer, giving `rd_count` = 3. In both, `eff_addr` is the address of the last read.
- R5: Mode 6 (displacement) and mode 7 (indexed) each read once at field + reg_val, taken modulo 2^DW, with `rd_count` = 1.
- R6: `mem_req` stays high with a stable `mem_addr` until a cycle in which `mem_valid` is high. At most one read is outstanding at a time.
- R7: Mode 8 (PC-relative) returns `operand` = `eff_addr` = pc + field, with the field taken as two's complement. It issues no memory read. For example, 200 + 6 gives 206, 1200 + 6 gives 1206 and 1200 - 4 gives 1196.
- R8: Mode 9 (post-increment) reads once at reg_val and returns `wb_en` = 1, `wb_val` = reg_val + STEP and `wb_reg` = reg_sel. Feeding `wb_val` back as reg_val therefore reads the next element.
- R9: Mode 10 (pre-decrement) returns `eff_addr` = `wb_val` = reg_val - STEP, `operand` = 0 and `rd_count` = 0, with `wb_en` = 1 and `wb_reg` = reg_sel. `wb_en` is never high outside a `done` cycle.
- R10: `done` is high for exactly one cycle per accepted request. The results stay unchanged after that cycle until the next request is accepted.
- R11: `start` is accepted only while `busy` is low. A start during a read sequence, or in the `done` cycle, has no effect. Field, reg_val, reg_sel and pc are sampled only in the accepting cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when not busy |
| mode | input | 4 | Addressing-mode code |
| field | input | DW | Instruction address/displacement field |
| reg_sel | input | RW | Register number of the base/pointer register |
| reg_val | input | DW | Contents of that register |
| pc | input | DW | Current program counter |
| mem_req | output | 1 | Read request |
| mem_addr | output | DW | Read address |
| mem_valid | input | 1 | Read data valid; completes the request |
| mem_rdata | input | DW | Read data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| operand | output | DW | Fetched or formed operand |
| eff_addr | output | DW | Effective address |
| rd_count | output | 2 | Number of memory reads used |
| wb_en | output | 1 | Register writeback strobe |
| wb_reg | output | RW | Register to write back |
| wb_val | output | DW | Updated pointer value |

## Verification
Two things can fall in the same cycle: the `done` strobe and a fresh `start` pulse. The same applies to a `start` pulse and an unfinished read sequence. The bench raises `start` in the very cycle it sees `done`. It then checks that no memory request and no second `done` follow. It also pulses `start` with an unrelated mode partway through random read sequences and checks that the original result, read count and writeback come out unchanged. Register and field inputs are scrambled straight after acceptance, which shows that only the sampled values are used.

// File: rtl/opfetch_unit.sv
module opfetch_unit #(
  parameter int DW   = 16,
  parameter int RW   = 3,
  parameter int STEP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [DW-1:0] field,
  input  logic [RW-1:0] reg_sel,
  input  logic [DW-1:0] reg_val,
  input  logic [DW-1:0] pc,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] operand,
  output logic [DW-1:0] eff_addr,
  output logic [1:0]    rd_count,
  output logic          wb_en,
  output logic [RW-1:0] wb_reg,
  output logic [DW-1:0] wb_val
);
  localparam logic [DW-1:0] STEP_W = DW'(STEP);
  localparam logic [3:0] M_IMM = 4'd0, M_REG = 4'd1, M_DIR = 4'd2, M_RIND = 4'd3,
                         M_MIND = 4'd4, M_DIND = 4'd5, M_DISP = 4'd6, M_IDX = 4'd7,
                         M_PCREL = 4'd8, M_POSTINC = 4'd9, M_PREDEC = 4'd10;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_FIN} state_t;
  state_t st;

  logic [DW-1:0] addr_q, opnd_q, ea_q, wbv_q;
  logic [1:0]    hops_q, cnt_q;
  logic          wbe_q;
  logic [RW-1:0] wreg_q;

  logic [DW-1:0] a0, o0, e0, w0;
  logic [1:0]    h0;
  logic          we0;
  logic [DW-1:0] sum_fr, sum_pc;

  assign sum_fr = field + reg_val;
  assign sum_pc = pc + field;

  always_comb begin
    a0 = '0; o0 = '0; e0 = '0; w0 = '0; h0 = 2'd0; we0 = 1'b0;
    case (mode)
      M_REG:     o0 = reg_val;
      M_DIR:     begin a0 = field;   h0 = 2'd1; end
      M_RIND:    begin a0 = reg_val; h0 = 2'd1; end
      M_MIND:    begin a0 = field;   h0 = 2'd2; end
      M_DIND:    begin a0 = field;   h0 = 2'd3; end
      M_DISP,
      M_IDX:     begin a0 = sum_fr;  h0 = 2'd1; end
      M_PCREL:   begin o0 = sum_pc;  e0 = sum_pc; end
      M_POSTINC: begin a0 = reg_val; h0 = 2'd1; we0 = 1'b1; w0 = reg_val + STEP_W; end
      M_PREDEC:  begin e0 = reg_val - STEP_W; w0 = reg_val - STEP_W; we0 = 1'b1; end
      default:   o0 = field;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      opnd_q <= '0;
      ea_q   <= '0;
      wbv_q  <= '0;
      hops_q <= 2'd0;
      cnt_q  <= 2'd0;
      wbe_q  <= 1'b0;
      wreg_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          addr_q <= a0;
          opnd_q <= o0;
          ea_q   <= e0;
          wbv_q  <= w0;
          wbe_q  <= we0;
          wreg_q <= reg_sel;
          hops_q <= h0;
          cnt_q  <= 2'd0;
          st     <= (h0 == 2'd0) ? S_FIN : S_READ;
        end
        S_READ: if (mem_valid) begin
          cnt_q <= cnt_q + 2'd1;
          if (hops_q == 2'd1) begin
            opnd_q <= mem_rdata;
            ea_q   <= addr_q;
            st     <= S_FIN;
          end else begin
            addr_q <= mem_rdata;
            hops_q <= hops_q - 2'd1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign done     = (st == S_FIN);
  assign mem_req  = (st == S_READ);
  assign mem_addr = addr_q;
  assign operand  = opnd_q;
  assign eff_addr = ea_q;
  assign rd_count = cnt_q;
  assign wb_en    = done & wbe_q;
  assign wb_reg   = wreg_q;
  assign wb_val   = wbv_q;
endmodule

// File: rtl/opfetch_unit_chk.sv
module opfetch_unit_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_valid,
  input logic [DW-1:0] mem_addr,
  input logic          wb_en
);
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  p_req_needs_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_req_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req);

  p_wb_only_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);

  p_done_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !busy);

  p_idle_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
endmodule

bind opfetch_unit opfetch_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_valid(mem_valid), .mem_addr(mem_addr), .wb_en(wb_en)
);

// File: tb/test_opfetch_unit.sv
`timescale 1ns/1ps
module test_opfetch_unit;
  localparam int DW = 16, RW = 3, STEP = 1;

  logic clk = 0, rst_n = 0, start = 0, mem_valid = 0;
  logic [3:0] mode = 0;
  logic [DW-1:0] field = 0, reg_val = 0, pc = 0, mem_rdata = 0;
  logic [RW-1:0] reg_sel = 0;
  logic mem_req, busy, done, wb_en;
  logic [DW-1:0] mem_addr, operand, eff_addr, wb_val;
  logic [1:0] rd_count;
  logic [RW-1:0] wb_reg;

  int errors = 0, checks = 0, reads_seen = 0, lat = 0, wait_c = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  opfetch_unit #(.DW(DW), .RW(RW), .STEP(STEP)) i_opfetch_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field(field),
    .reg_sel(reg_sel), .reg_val(reg_val), .pc(pc), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .operand(operand), .eff_addr(eff_addr),
    .rd_count(rd_count), .wb_en(wb_en), .wb_reg(wb_reg), .wb_val(wb_val));

  function automatic logic [DW-1:0] memfn(input logic [DW-1:0] a);
    return DW'(a * 16'd40503 + 16'd4661);
  endfunction

  function automatic void model(input logic [3:0] m, input logic [DW-1:0] f, r, p,
      output logic [DW-1:0] op, ea, wbv, output int n, output bit wbe);
    logic [DW-1:0] a;
    op = 0; ea = 0; wbv = 0; n = 0; wbe = 0;
    case (m)
      4'd1: op = r;
      4'd2: begin ea = f; op = memfn(ea); n = 1; end
      4'd3: begin ea = r; op = memfn(ea); n = 1; end
      4'd4: begin ea = memfn(f); op = memfn(ea); n = 2; end
      4'd5: begin a = memfn(f); ea = memfn(a); op = memfn(ea); n = 3; end
      4'd6, 4'd7: begin ea = DW'(f + r); op = memfn(ea); n = 1; end
      4'd8: begin ea = DW'(p + f); op = ea; end
      4'd9: begin ea = r; op = memfn(ea); n = 1; wbe = 1; wbv = DW'(r + STEP); end
      4'd10: begin ea = DW'(r - STEP); wbv = ea; wbe = 1; end
      default: op = f;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (mem_valid) begin
      mem_valid <= 0;
      wait_c <= 0;
    end else if (mem_req) begin
      if (wait_c >= lat) begin
        mem_valid <= 1;
        mem_rdata <= memfn(mem_addr);
        reads_seen <= reads_seen + 1;
        lat <= int'($urandom_range(0, 3));
      end else wait_c <= wait_c + 1;
    end
  end

  task automatic run_op(input string req, input logic [3:0] m, input logic [DW-1:0] f,
      input logic [RW-1:0] rs, input logic [DW-1:0] r, p, input bit inject,
      output logic [DW-1:0] wb_out);
    logic [DW-1:0] eop, eea, ewb;
    int en, base, n;
    bit ewe;
    model(m, f, r, p, eop, eea, ewb, en, ewe);
    base = reads_seen;
    mode = m; field = f; reg_sel = rs; reg_val = r; pc = p; start = 1;
    @(negedge clk);
    start = 0;
    mode = 4'($urandom); field = DW'($urandom); reg_val = DW'($urandom);
    pc = DW'($urandom); reg_sel = RW'($urandom);
    if (inject && !done) begin
      start = 1;
      @(negedge clk);
      start = 0;
    end
    n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(req, "done seen", {31'd0, done}, 32'd1);
    chk(req, "operand", operand, eop);
    chk(req, "eff_addr", eff_addr, eea);
    chk(req, "rd_count", rd_count, en);
    chk(req, "reads observed", reads_seen - base, en);
    chk(req, "wb_en", {31'd0, wb_en}, {31'd0, ewe});
    if (ewe) begin
      chk(req, "wb_val", wb_val, ewb);
      chk(req, "wb_reg", wb_reg, rs);
    end
    wb_out = wb_val;
    @(negedge clk);
    chk("R10", "done one cycle", {31'd0, done}, 32'd0);
    chk("R10", "operand held", operand, eop);
    chk("R10", "rd_count held", rd_count, en);
  endtask

  logic [DW-1:0] wbo, ptr;

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", {31'd0, busy}, 0);
    chk("R1", "mem_req in reset", {31'd0, mem_req}, 0);
    chk("R1", "done in reset", {31'd0, done}, 0);
    chk("R1", "wb_en in reset", {31'd0, wb_en}, 0);
    chk("R1", "operand in reset", operand, 0);
    chk("R1", "eff_addr in reset", eff_addr, 0);
    chk("R1", "rd_count in reset", rd_count, 0);
    rst_n = 1;
    @(negedge clk);

    run_op("R2", 4'd0, 16'd500, 3'd1, 16'd77, 16'd0, 0, wbo);
    run_op("R2", 4'd1, 16'd500, 3'd2, 16'd77, 16'd0, 0, wbo);
    run_op("R2", 4'd13, 16'd321, 3'd2, 16'd77, 16'd0, 0, wbo);
    run_op("R3", 4'd2, 16'd500, 3'd0, 16'd9, 16'd0, 0, wbo);
    run_op("R3", 4'd3, 16'd12, 3'd1, 16'd800, 16'd0, 0, wbo);
    run_op("R4", 4'd4, 16'd100, 3'd0, 16'd0, 16'd0, 0, wbo);
    run_op("R4", 4'd5, 16'd100, 3'd0, 16'd0, 16'd0, 0, wbo);
    run_op("R5", 4'd6, 16'd3, 3'd1, 16'd400, 16'd0, 0, wbo);
    run_op("R5", 4'd7, 16'hFFFF, 3'd2, 16'd5, 16'd0, 0, wbo);
    run_op("R7", 4'd8, 16'd6, 3'd0, 16'd0, 16'd200, 0, wbo);
    chk("R7", "pc 200 +6", eff_addr, 16'd206);
    run_op("R7", 4'd8, 16'd6, 3'd0, 16'd0, 16'd1200, 0, wbo);
    chk("R7", "pc 1200 +6", eff_addr, 16'd1206);
    run_op("R7", 4'd8, -16'sd4, 3'd0, 16'd0, 16'd1200, 0, wbo);
    chk("R7", "pc 1200 -4", eff_addr, 16'd1196);

    ptr = 16'd300;
    run_op("R8", 4'd9, 16'd0, 3'd4, ptr, 16'd0, 0, wbo);
    chk("R8", "first pointer step", wbo, 16'd301);
    run_op("R8", 4'd9, 16'd0, 3'd4, wbo, 16'd0, 0, wbo);
    chk("R8", "second read at next element", eff_addr, 16'd301);
    run_op("R9", 4'd10, 16'd0, 3'd3, 16'd600, 16'd0, 0, wbo);
    chk("R9", "push address", eff_addr, 16'd599);
    run_op("R9", 4'd10, 16'd0, 3'd3, 16'd0, 16'd0, 0, wbo);

    run_op("R11", 4'd5, 16'd42, 3'd0, 16'd0, 16'd0, 1, wbo);

    mode = 4'd2; field = 16'd77; start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
    mode = 4'd4; field = 16'd900; start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < 3; k++) begin
      chk("R11", "no request after done-cycle start", {31'd0, mem_req}, 0);
      chk("R11", "no done after done-cycle start", {31'd0, done}, 0);
      @(negedge clk);
    end

    for (int i = 0; i < 300; i++) begin
      logic [3:0] m;
      m = 4'($urandom_range(0, 15));
      run_op("R6", m, DW'($urandom), RW'($urandom), DW'($urandom), DW'($urandom),
             bit'($urandom_range(0, 1)), wbo);
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end
    summary();
  end
endmodule